// File: doc/BRIEF.md
# Parallel Port Register Block with Mode-Gated FIFO

This block is the register side of a byte-wide parallel port controller that sits on a simple memory-mapped bus. A host reads and writes a data latch, a pin-status register, a line-control register, a shared 16-byte FIFO window, two configuration registers and an extended control register. The top three bits of the extended control register pick an operating mode. That mode decides which registers respond, whether the FIFO accepts bytes, and who drives the data pins.

The three register-select bits sit above a mirror field. Every register therefore answers on a whole run of consecutive addresses, and only the high address bits matter. The block drives strobe, autofeed, init and select-in, and it samples busy, acknowledge, paper error, select and fault from the cable. It raises a one-cycle interrupt pulse when acknowledge returns high. In the FIFO-to-pins mode it empties the FIFO onto the data pins, one strobe pulse of fixed length per byte, and it waits whenever the printer reports busy.

Top module: `pp_port_ctl`

## Requirements
- R1: After reset the extended control register reads 0x15: mode 000 (standard), bits 4 and 2 set, bit 0 (FIFO empty) set. The control register and data latch read 0x00, the data pins are driven, and strobe and the interrupt are low.
- R2: The register is selected by bus_addr[10:8] only: 0 data, 1 status, 2 control, 3 FIFO, 4 configuration A, 5 configuration B, 6 extended control. A write at any value of bus_addr[7:0] is visible on a read at any other value.
- R3: Mode codes in extended control bits 7:5 are 000 standard, 001 bidirectional, 010 FIFO-to-pins, 011 extended-capability, 100 enhanced, 101 reserved, 110 FIFO test, 111 configuration. A write to extended control takes effect only if the current mode or the written mode is 000 or 001. Any other write is ignored completely, and both the mode and bits 4:2 keep their old values.
- R4: Extended control bit 1 reads FIFO full and bit 0 reads FIFO empty. Writes to these two bits have no effect.
- R5: A write to the FIFO address is stored only in modes 010, 011 and 110. A write when the FIFO already holds 16 bytes is dropped. In mode 110 a read of the FIFO address returns the oldest byte and removes it, so bytes come back in the order they were written.
- R6: Configuration A reads 0x90 (bit 7 set for level interrupts, bits 6:4 = 001 for 8-bit words) and configuration B reads back its stored value. Both read 0x00 in every mode other than 111. Configuration B accepts writes only in mode 111.
- R7: Control bits 3:0 drive selin_o, init_o, autofd_o and strobe_o in that order, from bit 3 down to bit 0, except in mode 010 where strobe_o comes from the FIFO engine. Bits 7:6 always read zero.
- R8: Status reads {busy_n, ack_n, perr, sel, fault_n, 000} from bit 7 down. The pins are captured in a register one clock before they can be read.
- R9: In mode 000 the data pins are always driven. In any other mode control bit 5 = 1 releases them (pd_oe low), and then a data read returns pd_in.
- R10: A mode-changing write that leaves mode 010, 011 or 110 empties the FIFO.
- R11: When control bit 4 is set, a rising edge on the sampled ack_n gives exactly one cycle of ack_irq_o. When bit 4 is clear, no pulse is produced.
- R12: In mode 010, while the FIFO is not empty and busy_n is high, bytes leave in FIFO order. Each byte is placed on pd_out during a strobe_o pulse lasting STB_CYC (3) cycles. While busy_n is low, nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 11 | Register select (bits 10:8) and mirror bits |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; consumes a FIFO byte in test mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pd_out | output | 8 | Data pins, outgoing value |
| pd_oe | output | 1 | Data pin output enable |
| pd_in | input | 8 | Data pins, incoming value |
| strobe_o | output | 1 | Strobe, active high |
| autofd_o | output | 1 | Autofeed, active high |
| init_o | output | 1 | Init line level |
| selin_o | output | 1 | Select-in, active high |
| busy_n_i | input | 1 | Printer not busy |
| ack_n_i | input | 1 | Acknowledge, active low |
| perr_i | input | 1 | Paper error |
| sel_i | input | 1 | Printer selected |
| fault_n_i | input | 1 | Fault, active low |
| ack_irq_o | output | 1 | Acknowledge interrupt pulse |

## Verification
A register write takes effect at the clock edge that captures it. The bench always reads back at the falling edge after that edge. Cable inputs pass through one sampling register, so status reads and the interrupt are checked one full cycle after a pin changes. The interrupt is sampled in the first and second falling edges after that capture, to prove the pulse is exactly one cycle long. The FIFO engine's start time depends on the busy sample and the engine state. The bench therefore samples strobe_o and pd_out at every falling edge over a window, records each pulse's byte and length, and compares them with the pushed sequence.

// File: rtl/pp_pkg.sv
// Shared definitions for the parallel port register block.
// Assumes a 3-bit register select above the mirror field.
package pp_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [2:0] {
        MD_SPP = 3'b000,
        MD_PS2 = 3'b001,
        MD_PPF = 3'b010,
        MD_ECP = 3'b011,
        MD_EPP = 3'b100,
        MD_RSV = 3'b101,
        MD_TST = 3'b110,
        MD_CFG = 3'b111
    } pp_mode_e;

    typedef enum logic [1:0] {DR_IDLE, DR_STB, DR_HOLD} pp_drain_st_e;

    localparam logic [SEL_W-1:0] RG_DATA = 3'd0;
    localparam logic [SEL_W-1:0] RG_STAT = 3'd1;
    localparam logic [SEL_W-1:0] RG_CTRL = 3'd2;
    localparam logic [SEL_W-1:0] RG_FIFO = 3'd3;
    localparam logic [SEL_W-1:0] RG_CFGA = 3'd4;
    localparam logic [SEL_W-1:0] RG_CFGB = 3'd5;
    localparam logic [SEL_W-1:0] RG_EXT  = 3'd6;

    localparam logic [7:0] CFGA_VALUE = 8'h90;

    function automatic logic is_basic(pp_mode_e m);
        return (m == MD_SPP) || (m == MD_PS2);
    endfunction

    function automatic logic is_fifo_mode(pp_mode_e m);
        return (m == MD_PPF) || (m == MD_ECP) || (m == MD_TST);
    endfunction
endpackage

// File: rtl/pp_fifo.sv
// Byte FIFO with synchronous flush. A push when full and a pop when empty
// are dropped. Assumes push and flush never arrive together.
module pp_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic         flush,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking, flush first.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pp_ext_ctl.sv
// Extended control register: holds the mode and bits 4:2, refuses a direct
// jump between two extended modes, and flushes the FIFO when a FIFO mode
// is left. Assumes we is a single-cycle write strobe.
module pp_ext_ctl
    import pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    output pp_mode_e   mode,
    output logic [7:0] rd_val,
    output logic       flush
);
    pp_mode_e   wr_mode;
    logic       legal;
    logic [2:0] low_q;

    assign wr_mode = pp_mode_e'(wdata[7:5]);
    assign legal   = is_basic(mode) || is_basic(wr_mode);
    assign flush   = we && legal && is_fifo_mode(mode) && (wr_mode != mode);
    assign rd_val  = {mode, low_q, fifo_full, fifo_empty};

    // Mode and control bits update on a legal write only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MD_SPP;
            low_q <= 3'b101;
        end else if (we && legal) begin
            mode  <= wr_mode;
            low_q <= wdata[4:2];
        end
    end
endmodule

// File: rtl/pp_drain.sv
// FIFO-to-pins engine: while enabled, takes one byte per transfer when the
// printer is not busy, holds it on the pins, raises strobe for STB_CYC
// cycles and then waits HOLD_CYC cycles. Assumes busy_n is already sampled.
module pp_drain
    import pp_pkg::*;
#(
    parameter int STB_CYC  = 3,
    parameter int HOLD_CYC = 2,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         busy_n,
    input  logic         empty,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic         strobe,
    output logic [W-1:0] byte_o
);
    localparam int MAXC = (STB_CYC > HOLD_CYC) ? STB_CYC : HOLD_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    pp_drain_st_e  st;
    logic [CW-1:0] cnt;

    assign pop    = enable && (st == DR_IDLE) && !empty && busy_n;
    assign strobe = (st == DR_STB);

    // Transfer sequencer: idle, strobe, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= DR_IDLE;
            cnt    <= '0;
            byte_o <= '0;
        end else if (!enable) begin
            st  <= DR_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                DR_IDLE: if (pop) begin
                    byte_o <= head;
                    st     <= DR_STB;
                    cnt    <= '0;
                end
                DR_STB: if (cnt == CW'(STB_CYC - 1)) begin
                    st  <= DR_HOLD;
                    cnt <= '0;
                end else cnt <= cnt + CW'(1);
                DR_HOLD: if (cnt == CW'(HOLD_CYC - 1)) begin
                    st  <= DR_IDLE;
                    cnt <= '0;
                end else cnt <= cnt + CW'(1);
                default: st <= DR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pp_port_ctl.sv
// Parallel port register block top. Decodes the mirrored register bus,
// keeps the data, control and configuration registers, samples the cable
// status pins, and connects the FIFO, mode register and FIFO engine.
// Assumes a single-cycle bus_we and bus_re and a combinational read.
module pp_port_ctl
    import pp_pkg::*;
#(
    parameter int MIRROR_W   = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int STB_CYC    = 3,
    parameter int HOLD_CYC   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [MIRROR_W+SEL_W-1:0] bus_addr,
    input  logic                      bus_we,
    input  logic                      bus_re,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    output logic [7:0]                pd_out,
    output logic                      pd_oe,
    input  logic [7:0]                pd_in,
    output logic                      strobe_o,
    output logic                      autofd_o,
    output logic                      init_o,
    output logic                      selin_o,
    input  logic                      busy_n_i,
    input  logic                      ack_n_i,
    input  logic                      perr_i,
    input  logic                      sel_i,
    input  logic                      fault_n_i,
    output logic                      ack_irq_o
);
    logic [SEL_W-1:0] sel;
    logic             unused_low;
    pp_mode_e         mode_w;
    logic [7:0]       ext_rd;
    logic             fifo_flush, fifo_full, fifo_empty, fifo_push, fifo_pop;
    logic [7:0]       fifo_head;
    logic             drain_pop, drain_stb;
    logic [7:0]       drain_byte;
    logic [7:0]       data_q;
    logic [5:0]       ctl_q;
    logic [7:0]       cfgb_q;
    logic [4:0]       pin_q;
    logic             ack_prev;

    assign sel        = bus_addr[MIRROR_W +: SEL_W];
    assign unused_low = ^bus_addr[MIRROR_W-1:0];

    pp_ext_ctl u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we && (sel == RG_EXT)),
        .wdata      (bus_wdata),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .mode       (mode_w),
        .rd_val     (ext_rd),
        .flush      (fifo_flush)
    );

    assign fifo_push = bus_we && (sel == RG_FIFO) && is_fifo_mode(mode_w);
    assign fifo_pop  = drain_pop || (bus_re && (sel == RG_FIFO) && (mode_w == MD_TST));

    pp_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .flush (fifo_flush),
        .wdata (bus_wdata),
        .head  (fifo_head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pp_drain #(.STB_CYC(STB_CYC), .HOLD_CYC(HOLD_CYC), .W(8)) u_drain (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mode_w == MD_PPF),
        .busy_n (pin_q[4]),
        .empty  (fifo_empty),
        .head   (fifo_head),
        .pop    (drain_pop),
        .strobe (drain_stb),
        .byte_o (drain_byte)
    );

    // Host-written data, control and configuration B registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ctl_q  <= '0;
            cfgb_q <= '0;
        end else if (bus_we) begin
            if (sel == RG_DATA) data_q <= bus_wdata;
            if (sel == RG_CTRL) ctl_q  <= bus_wdata[5:0];
            if ((sel == RG_CFGB) && (mode_w == MD_CFG)) cfgb_q <= bus_wdata;
        end
    end

    // Cable status sampling and acknowledge edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q    <= 5'b11001;
            ack_prev <= 1'b1;
        end else begin
            pin_q    <= {busy_n_i, ack_n_i, perr_i, sel_i, fault_n_i};
            ack_prev <= pin_q[3];
        end
    end

    assign ack_irq_o = ctl_q[4] && pin_q[3] && !ack_prev;

    // Pin drivers chosen by mode.
    always_comb begin
        pd_oe    = (mode_w == MD_SPP) ? 1'b1 : !ctl_q[5];
        pd_out   = (mode_w == MD_PPF) ? drain_byte : data_q;
        strobe_o = (mode_w == MD_PPF) ? drain_stb : ctl_q[0];
        autofd_o = ctl_q[1];
        init_o   = ctl_q[2];
        selin_o  = ctl_q[3];
    end

    // Read data multiplexer.
    always_comb begin
        case (sel)
            RG_DATA: bus_rdata = pd_oe ? data_q : pd_in;
            RG_STAT: bus_rdata = {pin_q, 3'b000};
            RG_CTRL: bus_rdata = {2'b00, ctl_q};
            RG_FIFO: bus_rdata = (mode_w == MD_TST) ? fifo_head : 8'h00;
            RG_CFGA: bus_rdata = (mode_w == MD_CFG) ? CFGA_VALUE : 8'h00;
            RG_CFGB: bus_rdata = (mode_w == MD_CFG) ? cfgb_q : 8'h00;
            RG_EXT:  bus_rdata = ext_rd;
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pp_port_chk.sv
// Assertion checker for pp_port_ctl, attached by bind below.
module pp_port_chk
    import pp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic [SEL_W-1:0] sel,
    input logic [7:0]       rdata,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic             fifo_pop,
    input logic             fifo_flush,
    input logic             pd_oe,
    input logic             ack_irq
);
    function automatic logic basic(logic [2:0] m);
        return (m == 3'b000) || (m == 3'b001);
    endfunction

    AST_MODE_VIA_BASIC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> (basic(mode) || basic($past(mode)))); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty)); // R4
    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_pop && !fifo_flush) |=> fifo_full); // R5
    AST_SPP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b000) |-> pd_oe); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> fifo_empty); // R10
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_irq |=> !ack_irq); // R11
    AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RG_CTRL) |-> (rdata[7:6] == 2'b00)); // R7
endmodule

bind pp_port_ctl pp_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_w),
    .sel        (sel),
    .rdata      (bus_rdata),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .fifo_flush (fifo_flush),
    .pd_oe      (pd_oe),
    .ack_irq    (ack_irq_o)
);

// File: tb/tb_pp_port_ctl.sv
// Directed bench for pp_port_ctl: one task per scenario.
module tb_pp_port_ctl;
    localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_CTRL = 3'd2,
                           A_FIFO = 3'd3, A_CFGA = 3'd4, A_CFGB = 3'd5,
                           A_EXT  = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, pd_out, pd_in = 8'h00;
    logic        pd_oe, strobe_o, autofd_o, init_o, selin_o, ack_irq_o;
    logic        busy_n_i = 1'b1, ack_n_i = 1'b1, perr_i = 1'b0;
    logic        sel_i = 1'b0, fault_n_i = 1'b1;
    logic [7:0]  lowc = 8'h00;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    pp_port_ctl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in), .strobe_o(strobe_o),
        .autofd_o(autofd_o), .init_o(init_o), .selin_o(selin_o),
        .busy_n_i(busy_n_i), .ack_n_i(ack_n_i), .perr_i(perr_i),
        .sel_i(sel_i), .fault_n_i(fault_n_i), .ack_irq_o(ack_irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_at(input logic [2:0] s, input logic [7:0] low, input logic [7:0] d);
        @(negedge clk);
        bus_addr = {s, low}; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        lowc = lowc + 8'd37;
        wr_at(s, lowc, d);
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        lowc = lowc + 8'd91;
        bus_addr = {s, lowc};
        #1 d = bus_rdata;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk);
        bus_addr = {A_FIFO, 8'h2c}; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic go_spp;
        wr(A_EXT, 8'h34);
        wr(A_EXT, 8'h14);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(A_EXT, v);  check("R1 ext reset", v, 8'h15);
        rd(A_CTRL, v); check("R1 ctrl reset", v, 8'h00);
        rd(A_DATA, v); check("R1 data reset", v, 8'h00);
        check("R1 oe/strobe/irq", {5'b0, pd_oe, strobe_o, ack_irq_o}, 8'h04);
    endtask

    task automatic t_mirror;
        logic [7:0] v;
        wr_at(A_DATA, 8'h00, 8'h5c);
        lowc = 8'hfe;
        rd(A_DATA, v); check("R2 mirror read", v, 8'h5c);
        wr_at(A_DATA, 8'hff, 8'h3a);
        lowc = 8'h00;
        rd(A_DATA, v); check("R2 mirror write", v, 8'h3a);
        check("R2 pins", pd_out, 8'h3a);
    endtask

    task automatic t_ctrl;
        logic [7:0] v;
        wr(A_CTRL, 8'hcf);
        rd(A_CTRL, v); check("R7 reserved zero", v, 8'h0f);
        check("R7 pins all", {4'b0, selin_o, init_o, autofd_o, strobe_o}, 8'h0f);
        wr(A_CTRL, 8'h05);
        check("R7 pins 05", {4'b0, selin_o, init_o, autofd_o, strobe_o}, 8'h05);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_status;
        logic [7:0] v;
        @(negedge clk);
        busy_n_i = 1; ack_n_i = 0; perr_i = 1; sel_i = 0; fault_n_i = 1;
        @(negedge clk);
        rd(A_STAT, v); check("R8 status a", v, 8'ha8);
        busy_n_i = 0; ack_n_i = 1; perr_i = 0; sel_i = 1; fault_n_i = 0;
        @(negedge clk);
        rd(A_STAT, v); check("R8 status b", v, 8'h50);
        busy_n_i = 1; fault_n_i = 1; sel_i = 0;
    endtask

    task automatic t_direction;
        logic [7:0] v;
        go_spp;
        wr(A_DATA, 8'h5c);
        pd_in = 8'ha7;
        wr(A_CTRL, 8'h20);
        check("R9 spp drives", {7'b0, pd_oe}, 8'h01);
        rd(A_DATA, v); check("R9 spp data", v, 8'h5c);
        wr(A_EXT, 8'h34);
        check("R9 ps2 released", {7'b0, pd_oe}, 8'h00);
        rd(A_DATA, v); check("R9 ps2 reads pins", v, 8'ha7);
        wr(A_CTRL, 8'h00);
        check("R9 ps2 forward", {7'b0, pd_oe}, 8'h01);
    endtask

    task automatic t_mode;
        logic [7:0] v;
        go_spp;
        wr(A_EXT, 8'h48);
        rd(A_EXT, v); check("R3 spp to ppf", v, 8'h49);
        wr(A_EXT, 8'h64);
        rd(A_EXT, v); check("R3 ppf to ecp refused", v, 8'h49);
        wr(A_EXT, 8'he0);
        rd(A_EXT, v); check("R3 ppf to cfg refused", v, 8'h49);
        wr(A_EXT, 8'h23);
        rd(A_EXT, v); check("R4 flag bits not writable", v, 8'h21);
        wr(A_EXT, 8'h64);
        rd(A_EXT, v); check("R3 ps2 to ecp", v, 8'h65);
    endtask

    task automatic t_fifo;
        logic [7:0] v;
        go_spp;
        wr(A_FIFO, 8'h77);
        wr(A_EXT, 8'hc0);
        rd(A_EXT, v); check("R5 spp write dropped", v, 8'hc1);
        for (int i = 0; i < 16; i++) wr(A_FIFO, 8'(i * 17 + 3));
        rd(A_EXT, v); check("R4 full flag", v, 8'hc2);
        wr(A_FIFO, 8'hee);
        for (int i = 0; i < 16; i++) begin
            pop(v); check("R5 pop order", v, 8'(i * 17 + 3));
        end
        rd(A_EXT, v); check("R4 empty after pops", v, 8'hc1);
    endtask

    task automatic t_flush;
        logic [7:0] v;
        go_spp;
        wr(A_EXT, 8'hc0);
        wr(A_FIFO, 8'h11);
        wr(A_FIFO, 8'h22);
        rd(A_EXT, v); check("R10 holds bytes", v, 8'hc0);
        wr(A_EXT, 8'h20);
        rd(A_EXT, v); check("R10 flushed", v, 8'h21);
        wr(A_EXT, 8'hc0);
        rd(A_EXT, v); check("R10 still empty", v, 8'hc1);
    endtask

    task automatic t_cfg;
        logic [7:0] v;
        go_spp;
        rd(A_CFGA, v); check("R6 cfgA hidden", v, 8'h00);
        wr(A_EXT, 8'he0);
        rd(A_CFGA, v); check("R6 cfgA value", v, 8'h90);
        wr(A_CFGB, 8'h5a);
        rd(A_CFGB, v); check("R6 cfgB readback", v, 8'h5a);
        wr(A_EXT, 8'h20);
        rd(A_CFGB, v); check("R6 cfgB hidden", v, 8'h00);
        wr(A_CFGB, 8'h11);
        wr(A_EXT, 8'he0);
        rd(A_CFGB, v); check("R6 cfgB write outside ignored", v, 8'h5a);
    endtask

    task automatic t_irq;
        go_spp;
        wr(A_CTRL, 8'h10);
        ack_n_i = 0;
        repeat (2) @(negedge clk);
        ack_n_i = 1;
        @(negedge clk); check("R11 pulse", {7'b0, ack_irq_o}, 8'h01);
        @(negedge clk); check("R11 one cycle", {7'b0, ack_irq_o}, 8'h00);
        wr(A_CTRL, 8'h00);
        ack_n_i = 0;
        repeat (2) @(negedge clk);
        ack_n_i = 1;
        @(negedge clk); check("R11 masked", {7'b0, ack_irq_o}, 8'h00);
        @(negedge clk); check("R11 masked late", {7'b0, ack_irq_o}, 8'h00);
    endtask

    task automatic t_drain;
        logic [7:0] v;
        logic [7:0] got [3];
        int         lens [3];
        int         n = 0, len = 0;
        logic       seen = 0, prev = 0;
        go_spp;
        wr(A_EXT, 8'h20);
        wr(A_EXT, 8'h40);
        busy_n_i = 0;
        @(negedge clk);
        wr(A_FIFO, 8'ha1);
        wr(A_FIFO, 8'hb2);
        wr(A_FIFO, 8'hc3);
        repeat (8) begin
            @(negedge clk);
            if (strobe_o) seen = 1;
        end
        check("R12 busy holds", {7'b0, seen}, 8'h00);
        rd(A_EXT, v); check("R12 bytes kept", v, 8'h40);
        busy_n_i = 1;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (strobe_o && !prev) begin
                if (n < 3) got[n] = pd_out;
                n++;
                len = 0;
            end
            if (strobe_o) len++;
            if (!strobe_o && prev && n <= 3) lens[n-1] = len;
            prev = strobe_o;
        end
        check("R12 pulse count", 8'(n), 8'd3);
        if (n == 3) begin
            check("R12 byte 0", got[0], 8'ha1);
            check("R12 byte 1", got[1], 8'hb2);
            check("R12 byte 2", got[2], 8'hc3);
            for (int i = 0; i < 3; i++) check("R12 strobe length", 8'(lens[i]), 8'd3);
        end
        rd(A_EXT, v); check("R12 drained", v, 8'h41);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_mirror;
        t_ctrl;
        t_status;
        t_direction;
        t_mode;
        t_fifo;
        t_flush;
        t_cfg;
        t_irq;
        t_drain;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule